// File: doc/BRIEF.md
# Serial USB Line Encoder with Operating Modes

The block turns a stream of bytes into one line symbol per clock: J, K or SE0, with a driver enable and a termination enable. Bytes arrive over a valid/ready handshake. A packet starts when a byte is accepted while the encoder is idle. It ends when no byte is waiting at the point where the last bit of the current byte is sent. One clock cycle equals one bit time.

A two-bit mode input selects how bytes become symbols. Mode 00 frames the data as a USB packet: a SYNC field, bit stuffing, NRZI coding and an end-of-packet marker. Mode 10 sends each data bit straight onto the line, with no framing and no coding. Modes 01 and 11 release the bus and withdraw the termination, so the port looks unplugged to the upstream side. The mode is sampled only while the encoder is idle. A change made during a packet therefore waits until that packet has finished.

Top module: `usb_tx_encoder`

## Requirements
- R1: In mode 00, each packet opens with the SYNC bits 0,0,0,0,0,0,0,1 in time order, NRZI coded, so the first driven symbol is K.
- R2: In mode 00, NRZI coding starts from J at the start of every packet. A 0 bit toggles the line between J and K, and a 1 bit leaves it unchanged.
- R3: In mode 00, a 0 is inserted after every run of six consecutive 1 bits, before NRZI coding. The run counts the final 1 of SYNC, continues across byte boundaries, and also applies after the last data bit of the packet.
- R4: In mode 00, the last data or stuff bit is followed by two cycles of SE0 and then one cycle of J, all with the driver enabled. The next cycle is idle: the driver is disabled and the line shows J.
- R5: Bytes are sent least significant bit first. ready_o is high while idle in mode 00 or 10, and during the cycle that sends bit 7 of a byte (never during a stuff bit). It is low during SYNC and while the other bits are shifted out. A packet ends when valid_i is low during that bit-7 cycle.
- R6: In mode 10, a 1 bit is driven as J and a 0 bit as K. No SYNC, stuffing or end-of-packet marker is produced. The driver turns off in the cycle after the last bit.
- R7: In mode 01, drive_en_o, term_en_o and ready_o are all low, and input bytes are ignored.
- R8: Mode 11 behaves exactly like mode 01.
- R9: The mode is taken from mode_i only while idle. A change made during a packet does not alter that packet's symbols or its termination, and takes effect in the first idle cycle after it.
- R10: line_o encodes SE0 as 00, J as 01 and K as 10, and never shows 11. After reset the encoder is idle, with the driver disabled and the line at J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bit time per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode: 00 normal, 01 non-driving, 10 raw, 11 reserved |
| data_i | input | 8 | Byte to transmit |
| valid_i | input | 1 | data_i holds a byte |
| ready_o | output | 1 | Byte is accepted at this edge when valid_i is high |
| line_o | output | 2 | Line symbol: 00 SE0, 01 J, 10 K |
| drive_en_o | output | 1 | Line driver enable |
| term_en_o | output | 1 | Termination enable, low in modes 01 and 11 |

## Verification
The bench sends every single-byte value in both framed and raw mode. It also sends multi-byte packets built so that runs of ones cross byte boundaries and end exactly on the last data bit. An encoder that reset its ones counter at each byte, or left out the counting of the SYNC's final 1, would place stuff bits wrongly. An encoder that checked for stuffing only inside a byte would go into SE0 without the trailing stuff bit. The raw sweep catches any leftover stuffing or framing, which would show up as extra symbols. Further cases change the mode in the middle of a packet: a design that did not latch the mode would cut the packet short or switch its coding halfway through. Modes 01 and 11 are held against a valid byte, and any design that accepts the byte or drives the line is caught.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_NODRIVE = 2'b01,
    MODE_RAW     = 2'b10,
    MODE_RSVD    = 2'b11
  } tx_mode_e;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10
  } line_sym_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_TAIL,
    ST_EOP
  } tx_state_e;

  function automatic line_sym_e level_sym(input logic lvl);
    return lvl ? SYM_J : SYM_K;
  endfunction

endpackage

// File: rtl/usb_tx_mode_ctrl.sv
module usb_tx_mode_ctrl
  import usb_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_i,
  input  logic [1:0] mode_i,
  output tx_mode_e   mode_o,
  output logic       drive_ok_o
);

  tx_mode_e mode_q;

  // mode follows the pin while idle, frozen otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= MODE_NORMAL;
    else if (idle_i) mode_q <= tx_mode_e'(mode_i);
  end

  assign mode_o     = idle_i ? tx_mode_e'(mode_i) : mode_q;
  assign drive_ok_o = (mode_o == MODE_NORMAL) || (mode_o == MODE_RAW);

endmodule

// File: rtl/usb_tx_nrzi_stuff.sv
module usb_tx_nrzi_stuff
  import usb_tx_pkg::*;
#(
  parameter int unsigned STUFF_LIMIT = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      restart_i,
  input  logic      adv_i,
  input  logic      bit_i,
  output logic      stuff_due_o,
  output logic      last_one_o,
  output line_sym_e sym_o
);

  localparam int unsigned CNT_W = $clog2(STUFF_LIMIT + 1);

  logic             lvl_q, lvl_d, emit;
  logic [CNT_W-1:0] ones_q;

  assign stuff_due_o = (ones_q == CNT_W'(STUFF_LIMIT));
  assign emit        = stuff_due_o ? 1'b0 : bit_i;
  assign lvl_d       = emit ? lvl_q : ~lvl_q;
  assign sym_o       = level_sym(lvl_d);
  // this bit completes a run, a stuff bit must follow
  assign last_one_o  = !stuff_due_o && bit_i && (ones_q == CNT_W'(STUFF_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      ones_q <= '0;
    end else if (restart_i) begin
      lvl_q  <= 1'b1;
      ones_q <= '0;
    end else if (adv_i) begin
      lvl_q  <= lvl_d;
      ones_q <= emit ? ones_q + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/usb_tx_encoder.sv
module usb_tx_encoder
  import usb_tx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_LEN    = 8,
  parameter int unsigned STUFF_LIMIT = 6,
  parameter int unsigned EOP_SE0_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [1:0]        line_o,
  output logic              drive_en_o,
  output logic              term_en_o
);

  localparam int unsigned MAX_A  = (DATA_W > SYNC_LEN) ? DATA_W : SYNC_LEN;
  localparam int unsigned CNT_MX = (MAX_A > EOP_SE0_LEN + 1) ? MAX_A : EOP_SE0_LEN + 1;
  localparam int unsigned CNT_W  = $clog2(CNT_MX + 1);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  tx_mode_e          mode;
  logic              drive_ok, raw;
  logic              adv, cbit, stuff_due, last_one;
  line_sym_e         coder_sym, sym;

  usb_tx_mode_ctrl u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (state_q == ST_IDLE),
    .mode_i    (mode_i),
    .mode_o    (mode),
    .drive_ok_o(drive_ok)
  );

  usb_tx_nrzi_stuff #(.STUFF_LIMIT(STUFF_LIMIT)) u_coder (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (state_q == ST_IDLE),
    .adv_i      (adv),
    .bit_i      (cbit),
    .stuff_due_o(stuff_due),
    .last_one_o (last_one),
    .sym_o      (coder_sym)
  );

  assign raw = (mode == MODE_RAW);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    ready_o    = 1'b0;
    drive_en_o = 1'b0;
    sym        = SYM_J;
    adv        = 1'b0;
    cbit       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ready_o = drive_ok;
        if (valid_i && drive_ok) begin
          sh_d    = data_i;
          cnt_d   = '0;
          state_d = raw ? ST_DATA : ST_SYNC;
        end
      end
      ST_SYNC: begin
        drive_en_o = 1'b1;
        adv        = 1'b1;
        cbit       = (cnt_q == CNT_W'(SYNC_LEN - 1));
        sym        = coder_sym;
        if (cnt_q == CNT_W'(SYNC_LEN - 1)) begin
          cnt_d   = '0;
          state_d = ST_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        drive_en_o = 1'b1;
        if (raw) begin
          sym = level_sym(sh_q[0]);
        end else begin
          adv  = 1'b1;
          cbit = sh_q[0];
          sym  = coder_sym;
        end
        // a stuff cycle holds the shifter
        if (raw || !stuff_due) begin
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            ready_o = 1'b1;
            cnt_d   = '0;
            if (valid_i) begin
              sh_d = data_i;
            end else if (raw) begin
              state_d = ST_IDLE;
            end else begin
              state_d = last_one ? ST_TAIL : ST_EOP;
            end
          end else begin
            sh_d  = sh_q >> 1;
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_TAIL: begin
        drive_en_o = 1'b1;
        adv        = 1'b1;
        sym        = coder_sym;
        state_d    = ST_EOP;
      end
      ST_EOP: begin
        drive_en_o = 1'b1;
        sym        = (cnt_q < CNT_W'(EOP_SE0_LEN)) ? SYM_SE0 : SYM_J;
        if (cnt_q == CNT_W'(EOP_SE0_LEN)) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end

  assign line_o    = sym;
  assign term_en_o = drive_ok;

endmodule

// File: rtl/usb_tx_encoder_chk.sv
module usb_tx_encoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_o,
  input logic [1:0] line_o,
  input logic       drive_en_o,
  input logic       term_en_o
);

  assert_no_se1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o != 2'b11);

  assert_idle_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_en_o |-> line_o == 2'b01);

  assert_drive_has_term_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o |-> term_en_o);

  assert_ready_has_term_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> term_en_o);

  assert_eop_second_se0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o && line_o == 2'b00 && !$past(drive_en_o && line_o == 2'b00))
    |=> (drive_en_o && line_o == 2'b00));

  assert_eop_j_after_se0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o && line_o == 2'b00 && $past(drive_en_o && line_o == 2'b00))
    |=> (drive_en_o && line_o == 2'b01));

endmodule

bind usb_tx_encoder usb_tx_encoder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_o   (ready_o),
  .line_o    (line_o),
  .drive_en_o(drive_en_o),
  .term_en_o (term_en_o)
);

// File: tb/usb_tx_encoder_test.sv
module usb_tx_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode;
  logic [7:0] data;
  logic       valid;
  logic       ready, drv, term;
  logic [1:0] line;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] pkt[8];
  logic [1:0] exp_line[128];
  logic       exp_en[128];
  int         exp_len;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usb_tx_encoder uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_i    (mode),
    .data_i    (data),
    .valid_i   (valid),
    .ready_o   (ready),
    .line_o    (line),
    .drive_en_o(drive_en_o_w),
    .term_en_o (term)
  );
  logic drive_en_o_w;
  assign drv = drive_en_o_w;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic put(input logic [1:0] s, input logic e);
    exp_line[exp_len] = s;
    exp_en[exp_len]   = e;
    exp_len++;
  endtask

  task automatic build_exp(input logic [1:0] m, input int n);
    int   ones = 0;
    logic lvl  = 1'b1;
    logic b;
    exp_len = 0;
    if (m == 2'b10) begin
      for (int i = 0; i < 8 * n; i++) put(pkt[i / 8][i % 8] ? J : K, 1'b1);
    end else begin
      for (int i = 0; i < 8 + 8 * n; i++) begin
        b = (i < 8) ? (i == 7) : pkt[(i - 8) / 8][(i - 8) % 8];
        if (!b) lvl = ~lvl;
        put(lvl ? J : K, 1'b1);
        if (b) begin
          ones++;
          if (ones == 6) begin
            lvl  = ~lvl;
            put(lvl ? J : K, 1'b1);
            ones = 0;
          end
        end else begin
          ones = 0;
        end
      end
      put(SE0, 1'b1);
      put(SE0, 1'b1);
      put(J, 1'b1);
    end
    put(J, 1'b0);
  endtask

  task automatic run_packet(input logic [1:0] m, input logic [1:0] mid, input int n);
    int    idx = 0, pos = 0, guard = 0;
    bit    hs, started = 0;
    string rq;
    logic  exp_t;
    build_exp(m, n);
    exp_t = (mid == 2'b00) || (mid == 2'b10);
    @(negedge clk);
    mode  = m;
    valid = 1'b1;
    data  = pkt[0];
    while (pos < exp_len && guard < 400) begin
      hs = valid && ready;
      @(negedge clk);
      guard++;
      if (hs) begin
        idx++;
        if (!started) mode = mid;
        started = 1;
      end
      if (started) begin
        if (m == 2'b10)            rq = "R6";
        else if (mid != m)         rq = "R9";
        else if (pos < 8)          rq = "R1";
        else if (pos >= exp_len - 4) rq = "R4";
        else                       rq = "R2 R3";
        chk(line == exp_line[pos], rq, line, exp_line[pos]);
        chk(drv == exp_en[pos], rq, drv, exp_en[pos]);
        chk(line != 2'b11, "R10", line, 0);
        if (pos < exp_len - 1) chk(term == 1'b1, "R9", term, 1);
        if (pos == 2) chk(ready == 1'b0, "R5", ready, 0);
        pos++;
      end
      if (idx < n) begin
        valid = 1'b1;
        data  = pkt[idx];
      end else begin
        valid = 1'b0;
      end
    end
    chk(guard < 400, "R5", guard, 400);
    chk(idx == n, "R5", idx, n);
    chk(term == exp_t, "R9", term, exp_t);
    chk(ready == exp_t, "R9", ready, exp_t);
    mode = 2'b00;
  endtask

  task automatic hold_off(input logic [1:0] m, input string req);
    @(negedge clk);
    mode  = m;
    valid = 1'b1;
    data  = 8'hFF;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(drv == 1'b0, req, drv, 0);
      chk(term == 1'b0, req, term, 0);
      chk(ready == 1'b0, req, ready, 0);
      chk(line == J, req, line, J);
    end
    valid = 1'b0;
    mode  = 2'b00;
    @(negedge clk);
    chk(term == 1'b1, req, term, 1);
    chk(ready == 1'b1, req, ready, 1);
    chk(drv == 1'b0, req, drv, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    mode  = 2'b00;
    valid = 1'b0;
    data  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv == 1'b0, "R10", drv, 0);
    chk(line == J, "R10", line, J);
    chk(term == 1'b1, "R10", term, 1);
    chk(ready == 1'b1, "R5", ready, 1);

    // framed sweep, all single-byte values (R1 R2 R3 R4)
    for (int b = 0; b < 256; b++) begin
      pkt[0] = 8'(b);
      run_packet(2'b00, 2'b00, 1);
    end
    // runs of ones across bytes and into the tail (R3)
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'hFF;
    run_packet(2'b00, 2'b00, 4);
    pkt[0] = 8'hE0; pkt[1] = 8'h07; pkt[2] = 8'hFC; pkt[3] = 8'h3F;
    run_packet(2'b00, 2'b00, 4);
    pkt[0] = 8'h7E; pkt[1] = 8'hFC;
    run_packet(2'b00, 2'b00, 2);
    pkt[0] = 8'h3E;
    run_packet(2'b00, 2'b00, 1);

    // raw sweep (R6)
    for (int b = 0; b < 256; b++) begin
      pkt[0] = 8'(b);
      run_packet(2'b10, 2'b10, 1);
    end
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h00; pkt[3] = 8'hA5;
    run_packet(2'b10, 2'b10, 4);

    // non-driving and reserved modes
    hold_off(2'b01, "R7");
    hold_off(2'b11, "R8");

    // mode changes during a packet (R9)
    pkt[0] = 8'hA5; pkt[1] = 8'hFF; pkt[2] = 8'hFF;
    run_packet(2'b00, 2'b01, 3);
    run_packet(2'b00, 2'b11, 3);
    run_packet(2'b00, 2'b10, 3);
    run_packet(2'b10, 2'b00, 3);
    run_packet(2'b10, 2'b01, 3);

    summary();
    $finish;
  end

endmodule